// File: doc/BRIEF.md
# Lane-Wise Vector Compare Unit with Recorded Summary

This block compares two 128-bit operand vectors lane by lane and returns a mask vector. Each lane of the mask is all ones where the compare holds and all zeros where it does not. Lanes may be 8, 16 or 32 bits wide. Three relations are offered: equality, signed greater-than and unsigned greater-than. A fourth mode checks signed 32-bit words against a symmetric range. In that mode each lane gets two flag bits that report which side of the range the operand fell outside.

When the record input accompanies a compare, the unit also writes a 4-bit condition field. This field tells software whether every lane was true, or whether every lane was false (or, in range mode, in range). The field is written only by recorded compares, so a loop can issue unrecorded compares without losing the last recorded summary.

The mask and condition field are registered, and results appear one cycle after the input strobe. A two-state sequencer drives the valid output. In **ST_IDLE** no result is being presented. In **ST_EMIT** a fresh result is on the outputs. The transitions are:
- **GO_EMIT**: from ST_IDLE, taken when `in_valid` is high.
- **STAY_EMIT**: in ST_EMIT, taken on back-to-back strobes.
- **GO_IDLE**: from ST_EMIT, taken when `in_valid` is low.
- **STAY_IDLE**: in ST_IDLE, taken with no strobe.

Top module: `simd_cmp`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid`, `out_mask` and `out_cond` are all zero until the first strobe.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: With `in_op`=0 (equality), each lane of `out_mask` is all ones if the operand lanes are equal and all zeros if not. The lane width comes from `in_size`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Lane 0 occupies the low bits.
- R4: With `in_op`=1, a lane is true when the A lane is greater than the B lane, both read as two's complement.
- R5: With `in_op`=2, a lane is true when the A lane is greater than the B lane, both read as unsigned.
- R6: With `in_op`=3 (range mode), lanes are always 32 bits whatever `in_size` is. In each lane, bit 31 is set when A > B and bit 30 is set when A < -B, computed signed without overflow. Bits 29..0 are zero. A negative B therefore always flags.
- R7: On a recorded compare with `in_op` 0..2, `out_cond[0]` is set if and only if every lane is true, and `out_cond[2]` is set if and only if every lane is false.
- R8: On a recorded range-mode compare, `out_cond[2]` is set if and only if every lane is in range (mask all zero), and `out_cond[0]` is zero.
- R9: `out_cond[1]` and `out_cond[3]` are always zero.
- R10: A compare with `in_record` low updates `out_mask` but leaves `out_cond` unchanged.
- R11: While `in_valid` is low, `out_mask` and `out_cond` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| in_a | input | 128 | Operand A |
| in_b | input | 128 | Operand B (the range limit in range mode) |
| in_op | input | 2 | 0 equal, 1 signed greater, 2 unsigned greater, 3 range |
| in_size | input | 2 | Lane width: 0 byte, 1 halfword, 2/3 word |
| in_record | input | 1 | Write the condition field for this compare |
| out_valid | output | 1 | Result presented this cycle |
| out_mask | output | 128 | Per-lane compare result |
| out_cond | output | 4 | Summary: bit 0 all true, bit 2 all false / all in range |

## Verification
The mask, the condition field and `out_valid` all come from one register stage. They are therefore due in the cycle after the strobe and are compared at the falling edge that follows that rising edge. Inputs are changed only at falling edges. After each strobe the bench inserts an idle cycle, and it checks there that valid has dropped and that the mask and condition field have held. A separate back-to-back pair checks that valid stays high across consecutive strobes. The expected condition field is tracked as a model that only recorded compares update.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 32;
    localparam int NUM_SIZES = 3;
    localparam int COND_W    = 4;

    typedef enum logic [1:0] {
        OP_EQ  = 2'd0,
        OP_GTS = 2'd1,
        OP_GTU = 2'd2,
        OP_BND = 2'd3
    } cmp_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } lane_sz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/simd_cmp_lane.sv
module simd_cmp_lane
    import simd_cmp_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  cmp_op_e       op,
    output logic [LW-1:0] lane_mask
);

    logic signed [LW:0] sa;
    logic signed [LW:0] sb;
    logic               hit;

    assign sa = $signed({a[LW-1], a});
    assign sb = $signed({b[LW-1], b});

    always_comb begin
        unique case (op)
            OP_EQ:   hit = (a == b);
            OP_GTS:  hit = (sa > sb);
            OP_GTU:  hit = (a > b);
            default: hit = 1'b0;
        endcase
        lane_mask = {LW{hit}};
    end

endmodule

// File: rtl/simd_cmp_bnd_lane.sv
module simd_cmp_bnd_lane #(
    parameter int LW = 32
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic [LW-1:0] lane_mask
);

    logic signed [LW:0] sa;
    logic signed [LW:0] sb;
    logic signed [LW:0] nb;

    assign sa = $signed({a[LW-1], a});
    assign sb = $signed({b[LW-1], b});
    assign nb = -sb;

    // Top bit: above upper limit; next bit: below lower limit.
    assign lane_mask = {(sa > sb), (sa < nb), {(LW-2){1'b0}}};

endmodule

// File: rtl/simd_cmp_array.sv
module simd_cmp_array
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]           a,
    input  logic [VEC_W-1:0]           b,
    input  cmp_op_e                    op,
    output logic [NUM_SIZES*VEC_W-1:0] size_mask,
    output logic [VEC_W-1:0]           bnd_mask
);

    localparam int NUM_WORDS = VEC_W / WORD_W;

    genvar g, l;
    generate
        for (g = 0; g < NUM_SIZES; g++) begin : g_size
            localparam int LW = BYTE_W << g;
            localparam int NL = VEC_W / LW;
            for (l = 0; l < NL; l++) begin : g_lane
                simd_cmp_lane #(.LW(LW)) u_lane (
                    .a         (a[l*LW +: LW]),
                    .b         (b[l*LW +: LW]),
                    .op        (op),
                    .lane_mask (size_mask[g*VEC_W + l*LW +: LW])
                );
            end
        end

        for (l = 0; l < NUM_WORDS; l++) begin : g_bnd
            simd_cmp_bnd_lane #(.LW(WORD_W)) u_bnd (
                .a         (a[l*WORD_W +: WORD_W]),
                .b         (b[l*WORD_W +: WORD_W]),
                .lane_mask (bnd_mask[l*WORD_W +: WORD_W])
            );
        end
    endgenerate

endmodule

// File: rtl/simd_cmp_summary.sv
module simd_cmp_summary
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]  mask,
    input  logic              is_bnd,
    output logic [COND_W-1:0] cond_nxt
);

    logic all_set;
    logic all_clr;

    assign all_set = &mask;
    assign all_clr = ~|mask;

    always_comb begin
        cond_nxt    = '0;
        cond_nxt[2] = all_clr;
        cond_nxt[0] = is_bnd ? 1'b0 : all_set;
    end

endmodule

// File: rtl/simd_cmp.sv
module simd_cmp
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  in_a,
    input  logic [VEC_W-1:0]  in_b,
    input  logic [1:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic              in_record,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_mask,
    output logic [COND_W-1:0] out_cond
);

    cmp_op_e                  op;
    lane_sz_e                 sz;
    logic [NUM_SIZES*VEC_W-1:0] size_mask;
    logic [VEC_W-1:0]         bnd_mask;
    logic [VEC_W-1:0]         mask_sel;
    logic [COND_W-1:0]        cond_nxt;
    seq_state_e               state_q;
    seq_state_e               state_d;

    assign op = cmp_op_e'(in_op);
    assign sz = lane_sz_e'(in_size);

    simd_cmp_array #(.VEC_W(VEC_W)) u_array (
        .a         (in_a),
        .b         (in_b),
        .op        (op),
        .size_mask (size_mask),
        .bnd_mask  (bnd_mask)
    );

    always_comb begin
        if (op == OP_BND) begin
            mask_sel = bnd_mask;
        end else begin
            unique case (sz)
                SZ_BYTE: mask_sel = size_mask[0*VEC_W +: VEC_W];
                SZ_HALF: mask_sel = size_mask[1*VEC_W +: VEC_W];
                default: mask_sel = size_mask[2*VEC_W +: VEC_W];
            endcase
        end
    end

    simd_cmp_summary #(.VEC_W(VEC_W)) u_summary (
        .mask     (mask_sel),
        .is_bnd   (op == OP_BND),
        .cond_nxt (cond_nxt)
    );

    // Sequencer next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_mask <= '0;
            out_cond <= '0;
        end else if (in_valid) begin
            out_mask <= mask_sel;
            if (in_record) out_cond <= cond_nxt;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

endmodule

// File: rtl/simd_cmp_chk.sv
module simd_cmp_chk
    import simd_cmp_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_record,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_mask,
    input logic [COND_W-1:0] out_cond
);

    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    assert_cond_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cond[1] == 1'b0) && (out_cond[3] == 1'b0));

    assert_cond_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_cond[0] && out_cond[2]));

    assert_cond_unrecorded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid && in_record)) |-> $stable(out_cond));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> $stable(out_mask));

endmodule

bind simd_cmp simd_cmp_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_record (in_record),
    .out_valid (out_valid),
    .out_mask  (out_mask),
    .out_cond  (out_cond)
);

// File: tb/simd_cmp_tb.sv
`timescale 1ns/1ps
module simd_cmp_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_a;
    logic [127:0] in_b;
    logic [1:0]   in_op;
    logic [1:0]   in_size;
    logic         in_record;
    logic         out_valid;
    logic [127:0] out_mask;
    logic [3:0]   out_cond;

    int checks = 0;
    int errors = 0;
    logic [3:0]   cond_model;
    logic [127:0] mask_model;

    always #2.5 clk = ~clk;

    simd_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_op(in_op), .in_size(in_size), .in_record(in_record),
        .out_valid(out_valid), .out_mask(out_mask), .out_cond(out_cond)
    );

    function automatic logic [127:0] ref_mask(logic [127:0] a, logic [127:0] b,
                                              logic [1:0] op, logic [1:0] sz);
        logic [127:0] r = '0;
        int w = (op == 2'd3) ? 32 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        longint m = (longint'(1) << w) - 1;
        for (int i = 0; i < 128 / w; i++) begin
            logic [63:0] ta = 64'(a >> (i * w));
            logic [63:0] tb = 64'(b >> (i * w));
            longint ua = longint'(ta) & m;
            longint ub = longint'(tb) & m;
            longint sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
            longint sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
            logic [127:0] lane = '0;
            if (op == 2'd3) begin
                lane[31] = (sa > sb);
                lane[30] = (sa < -sb);
            end else begin
                logic hit;
                case (op)
                    2'd0:    hit = (ua == ub);
                    2'd1:    hit = (sa > sb);
                    default: hit = (ua > ub);
                endcase
                if (hit) lane = 128'(m);
            end
            r = r | (lane << (i * w));
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_cond(logic [127:0] mk, logic [1:0] op);
        logic [3:0] c = '0;
        c[2] = (mk == '0);
        c[0] = (op != 2'd3) && (mk == {128{1'b1}});
        return c;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; result sampled at the next falling edge.
    task automatic step(logic [127:0] a, logic [127:0] b, logic [1:0] op,
                        logic [1:0] sz, logic rec, string req);
        in_a = a; in_b = b; in_op = op; in_size = sz; in_record = rec; in_valid = 1'b1;
        mask_model = ref_mask(a, b, op, sz);
        if (rec) cond_model = ref_cond(mask_model, op);
        @(negedge clk);
        chk({req, " R2 valid"}, 128'(out_valid), 128'(1'b1));
        chk({req, " mask"}, out_mask, mask_model);
        chk({req, " cond R9/R10"}, 128'(out_cond), 128'(cond_model));
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_a = {4{$urandom}}; in_b = {4{$urandom}}; in_record = 1'b1;
        @(negedge clk);
        chk("R2 valid low", 128'(out_valid), 128'(1'b0));
        chk("R11 mask held", out_mask, mask_model);
        chk("R11 cond held", 128'(out_cond), 128'(cond_model));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c3a));
        rst_n = 1'b0; in_valid = 1'b1; in_a = '1; in_b = '0;
        in_op = 2'd0; in_size = 2'd0; in_record = 1'b1;
        cond_model = '0; mask_model = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 128'(out_valid), 128'(1'b0));
        chk("R1 mask in reset", out_mask, '0);
        chk("R1 cond in reset", 128'(out_cond), '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 128'(out_valid), 128'(1'b0));
        chk("R1 mask after reset", out_mask, '0);

        // R3 equality, all true at byte size
        step(128'h0123_4567_89ab_cdef_0011_2233_4455_6677, 128'h0123_4567_89ab_cdef_0011_2233_4455_6677,
             2'd0, 2'd0, 1'b1, "R3 R7 eq all true");
        chk("R7 cond all true", 128'(out_cond), 128'h1);
        idle();
        // R3 halfword with one lane differing
        step(128'h1111_2222_3333_4444_5555_6666_7777_8888, 128'h1111_2222_3333_4444_5555_6666_7777_8889,
             2'd0, 2'd1, 1'b1, "R3 eq half");
        chk("R3 eq half lane0", out_mask, {{112{1'b1}}, 16'h0});
        idle();
        // R4/R5 signed vs unsigned bytes: 0xFF vs 0x01
        step({16{8'hFF}}, {16{8'h01}}, 2'd1, 2'd0, 1'b1, "R4 gts byte");
        chk("R7 cond all false", 128'(out_cond), 128'h4);
        idle();
        step({16{8'hFF}}, {16{8'h01}}, 2'd2, 2'd0, 1'b0, "R5 R10 gtu unrecorded");
        chk("R5 gtu all ones", out_mask, {128{1'b1}});
        chk("R10 cond kept", 128'(out_cond), 128'h4);
        idle();
        // Word extremes; size 3 treated as word
        step({4{32'h8000_0000}}, {4{32'h7fff_ffff}}, 2'd1, 2'd3, 1'b1, "R4 gts word min");
        idle();
        step({4{32'h8000_0000}}, {4{32'h7fff_ffff}}, 2'd2, 2'd3, 1'b1, "R5 gtu word");
        idle();
        // R6/R8 range mode
        step({4{32'd5}}, {4{32'd10}}, 2'd3, 2'd0, 1'b1, "R8 all in range");
        chk("R8 cond in range", 128'(out_cond), 128'h4);
        idle();
        step({32'd11, 32'hFFFF_FFF5, 32'd10, 32'hFFFF_FFF6}, {4{32'd10}}, 2'd3, 2'd1, 1'b1, "R6 range edges");
        chk("R6 flags", out_mask, {32'h8000_0000, 32'h4000_0000, 32'h0, 32'h0});
        chk("R8 cond not all", 128'(out_cond), 128'h0);
        idle();
        step({4{32'h0}}, {4{32'h8000_0000}}, 2'd3, 2'd2, 1'b1, "R6 negative limit");
        idle();
        // Back-to-back strobes keep valid high
        step(rnd128(), rnd128(), 2'd1, 2'd1, 1'b1, "R2 b2b first");
        step(rnd128(), rnd128(), 2'd2, 2'd0, 1'b0, "R2 b2b second");
        idle();

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [127:0] a = rnd128();
            logic [127:0] b;
            logic [1:0] op = 2'($urandom % 4);
            int pick = $urandom % 4;
            if (pick == 0)      b = a;
            else if (pick == 1) b = a ^ (128'h1 << ($urandom % 128));
            else                b = rnd128();
            if (op == 2'd3 && pick >= 2) b = b & {4{32'h0FFF_FFFF}};
            step(a, b, op, 2'($urandom % 4), 1'($urandom % 2), "R3/R4/R5/R6 random");
            if ($urandom % 3 == 0) idle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule